// File: doc/BRIEF.md
# Mailbox and Interrupt Status Controller

This block sits inside a host-to-local bus bridge and collects every interrupt cause that passes between the two sides. It holds eight 32-bit mailboxes and two doorbell registers, one for each direction. It also holds one 32-bit control/status word. That word combines per-source enable bits with live, read-only activity bits. The block has two register ports, one for the host side and one for the local side. It also takes interrupt requests from two DMA channels and from a local interrupt pin.

From these inputs the block drives an interrupt towards the host and an interrupt towards the local processor. Each DMA channel is routed to one of the two sides by a static select input. A host write to one of the first four mailboxes flags a message for the local side. When the local side reads that mailbox, the flag clears.

Both ports use a single-cycle register access. A write takes effect at the clock edge where the request is high. Read data is combinational from the current register state. Both interrupt outputs are combinational from the registers and the live inputs.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset, all mailboxes, both doorbells, all enables and all mailbox flags are 0. With the interrupt inputs low, the control word reads 0 and both interrupt outputs are low.
- R2: Mailbox n (n = 0..7) is at byte address 0x40 + 4n and can be read and written from either port. If both ports write the same mailbox in one cycle, the host data is kept.
- R3: A host write to mailbox n (n = 0..3) while control bit 3 is set sets flag bit 28+n of the control word one cycle later. With bit 3 clear, the flag is not set. A local write to a mailbox never sets a flag.
- R4: A local read of mailbox n (n = 0..3) clears flag 28+n. A host read leaves the flag unchanged. If a setting host write and a clearing local read happen in the same cycle, the flag ends up set.
- R5: The local doorbell at 0x60 is write-one-to-set from the host and write-one-to-clear from the local side. When both act on one bit in the same cycle, the set wins. Control bit 20 reads as the OR of its bits.
- R6: The host doorbell at 0x64 is write-one-to-set from the local side and write-one-to-clear from the host. Control bit 13 reads as the OR of its bits.
- R7: The control word at 0x68 stores only bits 3, 8, 9, 11, 16, 17, 18 and 19 (mask 0x000F0B08). Written values on all other bits are ignored. Bit 15 shows the local interrupt input. Bits 21 and 22 show DMA channel 0 and 1 requests.
- R8: host_irq_o is high exactly when bit 8 is set and at least one of the following holds: bit 9 is set and bit 13 is active; bit 11 is set and the local input is high; or DMA channel c has its enable (bit 18+c) set, its request high, and its route select at 1.
- R9: local_irq_o is high exactly when bit 16 is set and at least one of the following holds: bit 3 is set and any mailbox flag is set; bit 17 is set and bit 20 is active; or DMA channel c is enabled with its request high and its route select at 0.
- R10: Addresses outside the map, or with nonzero low two bits, read as 0, and writes to them change nothing.
- R11: If both ports write the control word in one cycle, the host value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_req_i | input | 1 | Host port access strobe |
| h_we_i | input | 1 | Host port write (1) or read (0) |
| h_addr_i | input | 8 | Host port byte address |
| h_wdata_i | input | 32 | Host port write data |
| h_rdata_o | output | 32 | Host port read data |
| l_req_i | input | 1 | Local port access strobe |
| l_we_i | input | 1 | Local port write (1) or read (0) |
| l_addr_i | input | 8 | Local port byte address |
| l_wdata_i | input | 32 | Local port write data |
| l_rdata_o | output | 32 | Local port read data |
| dma_irq_i | input | 2 | DMA channel interrupt requests |
| dma_to_host_i | input | 2 | Per-channel route select: 1 = host, 0 = local |
| lint_i | input | 1 | Local interrupt input, active high |
| host_irq_o | output | 1 | Interrupt towards the host |
| local_irq_o | output | 1 | Interrupt towards the local side |

## Verification
The hardest situations to reach from the ports are same-cycle collisions. One case is a host write that sets a mailbox flag while the local side reads the same mailbox to clear it. Others are one doorbell bit being set and cleared at once, and both ports writing the control word together. The bench drives both ports from one stimulus step, so it places these collisions deliberately. It then follows them with a long run of random two-port traffic over the mapped and unmapped addresses, with random DMA and local interrupt inputs. Throughout, a behavioural model checks every read and both interrupt outputs on every clock.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int N_MBOX   = 8;
  localparam int N_FLAG   = 4;
  localparam int N_DMA    = 2;
  localparam int MBX_IW   = $clog2(N_MBOX);

  // control word bit positions (decoded by software, so fixed)
  localparam int B_MBX_IEN  = 3;
  localparam int B_HOST_IEN = 8;
  localparam int B_HDB_IEN  = 9;
  localparam int B_LIN_IEN  = 11;
  localparam int B_HDB_ACT  = 13;
  localparam int B_LIN_ACT  = 15;
  localparam int B_LOC_IEN  = 16;
  localparam int B_LDB_IEN  = 17;
  localparam int B_DMA_IEN  = 18;
  localparam int B_LDB_ACT  = 20;
  localparam int B_DMA_ACT  = 21;
  localparam int B_MBX_FLAG = 28;

  localparam logic [DATA_W-1:0] CSR_RW_MASK =
      (DATA_W'(1) << B_MBX_IEN) | (DATA_W'(1) << B_HOST_IEN) |
      (DATA_W'(1) << B_HDB_IEN) | (DATA_W'(1) << B_LIN_IEN)  |
      (DATA_W'(1) << B_LOC_IEN) | (DATA_W'(1) << B_LDB_IEN)  |
      (DATA_W'((1 << N_DMA) - 1) << B_DMA_IEN);

  // word indexes (byte address >> 2)
  localparam logic [5:0] W_MBX_BASE = 6'h10;
  localparam logic [5:0] W_LDB      = 6'h18;
  localparam logic [5:0] W_HDB      = 6'h19;
  localparam logic [5:0] W_CSR      = 6'h1A;

  typedef struct packed {
    logic              mbx_hit;
    logic [MBX_IW-1:0] mbx_idx;
    logic              ldb_hit;
    logic              hdb_hit;
    logic              csr_hit;
  } dec_t;

  function automatic dec_t decode(input logic [ADDR_W-1:0] a);
    dec_t d;
    logic [5:0] w;
    d = '0;
    w = a[7:2];
    if (a[1:0] == 2'b00) begin
      if (w[5:3] == W_MBX_BASE[5:3]) begin
        d.mbx_hit = 1'b1;
        d.mbx_idx = w[2:0];
      end
      d.ldb_hit = (w == W_LDB);
      d.hdb_hit = (w == W_HDB);
      d.csr_hit = (w == W_CSR);
    end
    return d;
  endfunction
endpackage

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_irq_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           h_wr_i,
  input  logic [MBX_IW-1:0]              h_idx_i,
  input  logic [DATA_W-1:0]              h_wdata_i,
  input  logic                           l_wr_i,
  input  logic [MBX_IW-1:0]              l_idx_i,
  input  logic [DATA_W-1:0]              l_wdata_i,
  input  logic                           l_rd_i,
  input  logic                           flag_en_i,
  output logic [N_MBOX-1:0][DATA_W-1:0]  mbox_o,
  output logic [N_FLAG-1:0]              flag_o
);
  for (genvar g = 0; g < N_MBOX; g++) begin : g_mbx
    logic h_sel, l_sel;
    assign h_sel = (h_idx_i == MBX_IW'(g));
    assign l_sel = (l_idx_i == MBX_IW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                mbox_o[g] <= '0;
      else if (h_wr_i && h_sel)   mbox_o[g] <= h_wdata_i;
      else if (l_wr_i && l_sel)   mbox_o[g] <= l_wdata_i;
    end

    if (g < N_FLAG) begin : g_flag
      // set has priority over a same-cycle clearing read
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             flag_o[g] <= 1'b0;
        else if (h_wr_i && h_sel && flag_en_i)   flag_o[g] <= 1'b1;
        else if (l_rd_i && l_sel)                flag_o[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbell_reg.sv
module dbell_reg
  import mbx_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [DATA_W-1:0] set_bits_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] clr_bits_i,
  output logic [DATA_W-1:0] q_o,
  output logic              active_o
);
  logic [DATA_W-1:0] set_m, clr_m;
  assign set_m = set_i ? set_bits_i : '0;
  assign clr_m = clr_i ? clr_bits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_m) | set_m;
  end

  assign active_o = |q_o;
endmodule

// File: rtl/mbx_irq_route.sv
module mbx_irq_route
  import mbx_irq_pkg::*;
(
  input  logic             host_ien_i,
  input  logic             hdb_ien_i,
  input  logic             hdb_act_i,
  input  logic             lin_ien_i,
  input  logic             lint_i,
  input  logic             loc_ien_i,
  input  logic             mbx_ien_i,
  input  logic [N_FLAG-1:0] flag_i,
  input  logic             ldb_ien_i,
  input  logic             ldb_act_i,
  input  logic [N_DMA-1:0] dma_ien_i,
  input  logic [N_DMA-1:0] dma_irq_i,
  input  logic [N_DMA-1:0] dma_to_host_i,
  output logic             host_irq_o,
  output logic             local_irq_o
);
  logic [N_DMA-1:0] dma_live;
  assign dma_live = dma_ien_i & dma_irq_i;

  assign host_irq_o = host_ien_i &
      ((hdb_ien_i & hdb_act_i) | (lin_ien_i & lint_i) |
       (|(dma_live & dma_to_host_i)));

  assign local_irq_o = loc_ien_i &
      ((mbx_ien_i & (|flag_i)) | (ldb_ien_i & ldb_act_i) |
       (|(dma_live & ~dma_to_host_i)));
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              h_req_i,
  input  logic              h_we_i,
  input  logic [ADDR_W-1:0] h_addr_i,
  input  logic [DATA_W-1:0] h_wdata_i,
  output logic [DATA_W-1:0] h_rdata_o,
  input  logic              l_req_i,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic [N_DMA-1:0]  dma_irq_i,
  input  logic [N_DMA-1:0]  dma_to_host_i,
  input  logic              lint_i,
  output logic              host_irq_o,
  output logic              local_irq_o
);
  dec_t h_dec, l_dec;
  assign h_dec = decode(h_addr_i);
  assign l_dec = decode(l_addr_i);

  logic h_wr, l_wr, l_rd;
  assign h_wr = h_req_i & h_we_i;
  assign l_wr = l_req_i & l_we_i;
  assign l_rd = l_req_i & ~l_we_i;

  logic [DATA_W-1:0] csr_en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     csr_en_q <= '0;
    else if (h_wr && h_dec.csr_hit)  csr_en_q <= h_wdata_i & CSR_RW_MASK;
    else if (l_wr && l_dec.csr_hit)  csr_en_q <= l_wdata_i & CSR_RW_MASK;
  end

  logic [N_MBOX-1:0][DATA_W-1:0] mbox;
  logic [N_FLAG-1:0]             mbx_flag;

  mbx_bank i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .h_wr_i    (h_wr & h_dec.mbx_hit),
    .h_idx_i   (h_dec.mbx_idx),
    .h_wdata_i (h_wdata_i),
    .l_wr_i    (l_wr & l_dec.mbx_hit),
    .l_idx_i   (l_dec.mbx_idx),
    .l_wdata_i (l_wdata_i),
    .l_rd_i    (l_rd & l_dec.mbx_hit),
    .flag_en_i (csr_en_q[B_MBX_IEN]),
    .mbox_o    (mbox),
    .flag_o    (mbx_flag)
  );

  // ldb: rings the local side; hdb: rings the host side
  logic [DATA_W-1:0] ldb_q, hdb_q;
  logic              ldb_act, hdb_act;

  dbell_reg i_ldb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (h_wr & h_dec.ldb_hit),
    .set_bits_i (h_wdata_i),
    .clr_i      (l_wr & l_dec.ldb_hit),
    .clr_bits_i (l_wdata_i),
    .q_o        (ldb_q),
    .active_o   (ldb_act)
  );

  dbell_reg i_hdb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (l_wr & l_dec.hdb_hit),
    .set_bits_i (l_wdata_i),
    .clr_i      (h_wr & h_dec.hdb_hit),
    .clr_bits_i (h_wdata_i),
    .q_o        (hdb_q),
    .active_o   (hdb_act)
  );

  logic [DATA_W-1:0] csr_view;
  always_comb begin
    csr_view            = csr_en_q;
    csr_view[B_HDB_ACT] = hdb_act;
    csr_view[B_LIN_ACT] = lint_i;
    csr_view[B_LDB_ACT] = ldb_act;
    for (int c = 0; c < N_DMA; c++)  csr_view[B_DMA_ACT + c]  = dma_irq_i[c];
    for (int m = 0; m < N_FLAG; m++) csr_view[B_MBX_FLAG + m] = mbx_flag[m];
  end

  function automatic logic [DATA_W-1:0] rd_sel(input dec_t d);
    if (d.mbx_hit) return mbox[d.mbx_idx];
    if (d.ldb_hit) return ldb_q;
    if (d.hdb_hit) return hdb_q;
    if (d.csr_hit) return csr_view;
    return '0;
  endfunction

  assign h_rdata_o = rd_sel(h_dec);
  assign l_rdata_o = rd_sel(l_dec);

  mbx_irq_route i_route (
    .host_ien_i    (csr_en_q[B_HOST_IEN]),
    .hdb_ien_i     (csr_en_q[B_HDB_IEN]),
    .hdb_act_i     (hdb_act),
    .lin_ien_i     (csr_en_q[B_LIN_IEN]),
    .lint_i        (lint_i),
    .loc_ien_i     (csr_en_q[B_LOC_IEN]),
    .mbx_ien_i     (csr_en_q[B_MBX_IEN]),
    .flag_i        (mbx_flag),
    .ldb_ien_i     (csr_en_q[B_LDB_IEN]),
    .ldb_act_i     (ldb_act),
    .dma_ien_i     (csr_en_q[B_DMA_IEN +: N_DMA]),
    .dma_irq_i     (dma_irq_i),
    .dma_to_host_i (dma_to_host_i),
    .host_irq_o    (host_irq_o),
    .local_irq_o   (local_irq_o)
  );
endmodule

// File: rtl/mbx_irq_checker.sv
module mbx_irq_checker
  import mbx_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              h_req_i,
  input logic              h_we_i,
  input logic [ADDR_W-1:0] h_addr_i,
  input logic              l_req_i,
  input logic              l_we_i,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic [DATA_W-1:0] l_wdata_i,
  input logic [DATA_W-1:0] csr_en_i,
  input logic [N_FLAG-1:0] flag_i,
  input logic [DATA_W-1:0] ldb_i,
  input logic              host_irq_i,
  input logic              local_irq_i
);
  logic h_wr_flagmbx, l_rd_flagmbx, same_addr_hwr;
  logic h_csr_wr, l_csr_wr, h_ldb_wr, l_ldb_wr;
  assign h_wr_flagmbx  = h_req_i && h_we_i && (h_addr_i[7:4] == 4'h4) && (h_addr_i[1:0] == 2'b00);
  assign l_rd_flagmbx  = l_req_i && !l_we_i && (l_addr_i[7:4] == 4'h4) && (l_addr_i[1:0] == 2'b00);
  assign same_addr_hwr = h_req_i && h_we_i && (h_addr_i == l_addr_i);
  assign h_csr_wr      = h_req_i && h_we_i && (h_addr_i == 8'h68);
  assign l_csr_wr      = l_req_i && l_we_i && (l_addr_i == 8'h68);
  assign h_ldb_wr      = h_req_i && h_we_i && (h_addr_i == 8'h60);
  assign l_ldb_wr      = l_req_i && l_we_i && (l_addr_i == 8'h60);

  assert_flag_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_wr_flagmbx && csr_en_i[B_MBX_IEN]) |=> flag_i[$past(h_addr_i[3:2])]);

  assert_flag_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_rd_flagmbx && !same_addr_hwr) |=> !flag_i[$past(l_addr_i[3:2])]);

  assert_ldb_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_ldb_wr && !h_ldb_wr) |=> ((ldb_i & $past(l_wdata_i)) == '0));

  assert_csr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!h_csr_wr && !l_csr_wr) |=> $stable(csr_en_i));

  assert_host_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_en_i[B_HOST_IEN] |-> !host_irq_i);

  assert_local_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_en_i[B_LOC_IEN] |-> !local_irq_i);
endmodule

bind mbx_irq_ctrl mbx_irq_checker i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .h_req_i     (h_req_i),
  .h_we_i      (h_we_i),
  .h_addr_i    (h_addr_i),
  .l_req_i     (l_req_i),
  .l_we_i      (l_we_i),
  .l_addr_i    (l_addr_i),
  .l_wdata_i   (l_wdata_i),
  .csr_en_i    (csr_en_q),
  .flag_i      (mbx_flag),
  .ldb_i       (ldb_q),
  .host_irq_i  (host_irq_o),
  .local_irq_i (local_irq_o)
);

// File: tb/test_mbx_irq_ctrl.sv
module test_mbx_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req = 0, h_we = 0, l_req = 0, l_we = 0;
  logic [7:0]  h_addr = 0, l_addr = 0;
  logic [31:0] h_wdata = 0, l_wdata = 0;
  logic [31:0] h_rdata, l_rdata;
  logic [1:0]  dma = 0, route = 0;
  logic        lint = 0;
  logic        host_irq, local_irq;

  always #5 clk = ~clk;

  mbx_irq_ctrl i_mbx_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .h_req_i(h_req), .h_we_i(h_we), .h_addr_i(h_addr), .h_wdata_i(h_wdata), .h_rdata_o(h_rdata),
    .l_req_i(l_req), .l_we_i(l_we), .l_addr_i(l_addr), .l_wdata_i(l_wdata), .l_rdata_o(l_rdata),
    .dma_irq_i(dma), .dma_to_host_i(route), .lint_i(lint),
    .host_irq_o(host_irq), .local_irq_o(local_irq)
  );

  localparam logic [31:0] RWM = 32'h000F_0B08;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_mbox [8];
  logic [31:0] m_ldb = 0, m_hdb = 0, m_en = 0;
  logic [3:0]  m_flag = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_csr();
    return m_en | (32'(|m_hdb) << 13) | (32'(lint) << 15) | (32'(|m_ldb) << 20) |
           (32'(dma) << 21) | (32'(m_flag) << 28);
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    int w = int'(a[7:2]);
    if (a[1:0] != 2'b00) return 32'h0;
    if (w >= 16 && w < 24) return m_mbox[w-16];
    if (w == 24) return m_ldb;
    if (w == 25) return m_hdb;
    if (w == 26) return m_csr();
    return 32'h0;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    int w = int'(a[7:2]);
    if (a[1:0] != 2'b00) return "R10";
    if (w >= 16 && w < 24) return "R2";
    if (w == 24) return "R5";
    if (w == 25) return "R6";
    if (w == 26) return "R7";
    return "R10";
  endfunction

  function automatic logic m_host();
    return m_en[8] && ((m_en[9] && (|m_hdb)) || (m_en[11] && lint) ||
           (m_en[18] && dma[0] && route[0]) || (m_en[19] && dma[1] && route[1]));
  endfunction

  function automatic logic m_local();
    return m_en[16] && ((m_en[3] && (|m_flag)) || (m_en[17] && (|m_ldb)) ||
           (m_en[18] && dma[0] && !route[0]) || (m_en[19] && dma[1] && !route[1]));
  endfunction

  task automatic model_update();
    logic [31:0] old_en = m_en;
    logic        hw = h_req && h_we && (h_addr[1:0] == 0);
    logic        lw = l_req && l_we && (l_addr[1:0] == 0);
    logic        lr = l_req && !l_we && (l_addr[1:0] == 0);
    int          hi = int'(h_addr[7:2]);
    int          li = int'(l_addr[7:2]);
    logic [3:0]  s = 0, c = 0;
    logic [31:0] s32, c32;
    if (lw && li >= 16 && li < 24) m_mbox[li-16] = l_wdata;
    if (hw && hi >= 16 && hi < 24) m_mbox[hi-16] = h_wdata;
    if (hw && hi >= 16 && hi < 20 && old_en[3]) s[hi-16] = 1'b1;
    if (lr && li >= 16 && li < 20) c[li-16] = 1'b1;
    m_flag = (m_flag & ~c) | s;
    s32 = (hw && hi == 24) ? h_wdata : 32'h0;
    c32 = (lw && li == 24) ? l_wdata : 32'h0;
    m_ldb = (m_ldb & ~c32) | s32;
    s32 = (lw && li == 25) ? l_wdata : 32'h0;
    c32 = (hw && hi == 25) ? h_wdata : 32'h0;
    m_hdb = (m_hdb & ~c32) | s32;
    if (lw && li == 26) m_en = l_wdata & RWM;
    if (hw && hi == 26) m_en = h_wdata & RWM;
  endtask

  // compare at settle point, cross the edge, update model, return at negedge
  task automatic step();
    #1;
    if (h_req && !h_we) chk(tag_of(h_addr), h_rdata, m_read(h_addr));
    if (l_req && !l_we) chk(tag_of(l_addr), l_rdata, m_read(l_addr));
    chk("R8", 32'(host_irq), 32'(m_host()));
    chk("R9", 32'(local_irq), 32'(m_local()));
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    h_req = 0; h_we = 0; l_req = 0; l_we = 0;
  endtask
  task automatic hset(logic we, logic [7:0] a, logic [31:0] d);
    h_req = 1; h_we = we; h_addr = a; h_wdata = d;
  endtask
  task automatic lset(logic we, logic [7:0] a, logic [31:0] d);
    l_req = 1; l_we = we; l_addr = a; l_wdata = d;
  endtask
  task automatic hw(logic [7:0] a, logic [31:0] d); idle(); hset(1, a, d); step(); endtask
  task automatic lw(logic [7:0] a, logic [31:0] d); idle(); lset(1, a, d); step(); endtask
  task automatic hr(logic [7:0] a);                 idle(); hset(0, a, 0); step(); endtask
  task automatic lr(logic [7:0] a);                 idle(); lset(0, a, 0); step(); endtask
  // directed literal check of a host read
  task automatic hpeek(logic [7:0] a, logic [31:0] exp, string tag);
    idle(); hset(0, a, 0); #1; chk(tag, h_rdata, exp); step();
  endtask

  function automatic logic [7:0] pick_addr();
    int r = $urandom % 12;
    if (r < 8) return 8'h40 + 8'(r * 4);
    if (r == 8) return 8'h60;
    if (r == 9) return 8'h64;
    if (r == 10) return 8'h68;
    return 8'h7C;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_mbox[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state
    #1;
    chk("R1 host_irq", 32'(host_irq), 0);
    chk("R1 local_irq", 32'(local_irq), 0);
    hpeek(8'h68, 32'h0, "R1 csr");
    hpeek(8'h44, 32'h0, "R1 mbox");

    // R2: mailbox read/write both ports
    for (int i = 0; i < 8; i++) hw(8'h40 + 8'(4*i), 32'hA500_0000 + 32'(i));
    for (int i = 0; i < 8; i++) lr(8'h40 + 8'(4*i));
    lw(8'h5C, 32'hDEAD_BEEF);
    hpeek(8'h5C, 32'hDEAD_BEEF, "R2 local write");
    idle(); hset(1, 8'h50, 32'h1111_1111); lset(1, 8'h50, 32'h2222_2222); step();
    hpeek(8'h50, 32'h1111_1111, "R2 host wins");

    // R3: flags with mailbox irq enabled (bit3) and local output (bit16)
    hw(8'h68, 32'h0001_0008);
    hw(8'h44, 32'h0000_0044);
    hpeek(8'h68, 32'h2001_0008, "R3 flag1 set");
    #1; chk("R9 mailbox local irq", 32'(local_irq), 1); @(negedge clk);
    lw(8'h48, 32'h3);
    hw(8'h54, 32'h5);
    hpeek(8'h68, 32'h2001_0008, "R3 local/high mbox no flag");

    // R4: host read keeps, local read clears, set beats clear
    hr(8'h44);
    hpeek(8'h68, 32'h2001_0008, "R4 host read keeps");
    lr(8'h44);
    hpeek(8'h68, 32'h0001_0008, "R4 local read clears");
    idle(); hset(1, 8'h4C, 32'h7); lset(0, 8'h4C, 0); step();
    hpeek(8'h68, 32'h8001_0008, "R4 set beats clear");
    lr(8'h4C);

    // R5: local doorbell
    hw(8'h68, 32'h0003_0000);
    hw(8'h60, 32'h0000_0005);
    hpeek(8'h68, 32'h0013_0000, "R5 active");
    lw(8'h60, 32'h4);
    hpeek(8'h60, 32'h1, "R5 partial clear");
    idle(); hset(1, 8'h60, 32'h2); lset(1, 8'h60, 32'h3); step();
    hpeek(8'h60, 32'h2, "R5 set wins");
    lw(8'h60, 32'hFFFF_FFFF);

    // R6: host doorbell
    hw(8'h68, 32'h0000_0300);
    lw(8'h64, 32'h8000_0000);
    hpeek(8'h68, 32'h0000_2300, "R6 active");
    hw(8'h64, 32'h8000_0000);
    hpeek(8'h64, 32'h0, "R6 cleared");

    // R7 / R8: local input and DMA routing
    hw(8'h68, 32'hFFFF_FFFF);
    hpeek(8'h68, 32'h000F_0B08, "R7 mask");
    lint = 1; route = 2'b01; dma = 2'b11;
    hpeek(8'h68, 32'h006F_8B08, "R7 live status");
    lint = 0; hw(8'h68, 32'h0004_0100);
    #1; chk("R8 dma0 to host", 32'(host_irq), 1); @(negedge clk);
    hw(8'h68, 32'h0009_0000);
    #1; chk("R9 dma1 to local", 32'(local_irq), 1); @(negedge clk);
    dma = 0; route = 0;

    // R11: both ports write control word
    idle(); hset(1, 8'h68, 32'h0000_0900); lset(1, 8'h68, 32'h0003_0000); step();
    hpeek(8'h68, 32'h0000_0900, "R11 host wins");

    // R10: unmapped and misaligned
    hw(8'h7C, 32'hFFFF_FFFF);
    hw(8'h69, 32'hFFFF_FFFF);
    hw(8'h41, 32'h1234_5678);
    hpeek(8'h68, 32'h0000_0900, "R10 csr untouched");
    hpeek(8'h40, 32'hA500_0000, "R10 mbox untouched");
    hpeek(8'h7C, 32'h0, "R10 unmapped read");

    // random two-port traffic
    for (int k = 0; k < 600; k++) begin
      idle();
      if ($urandom % 2) hset(1'($urandom), pick_addr(), $urandom);
      if ($urandom % 2) lset(1'($urandom), pick_addr(), $urandom);
      dma = 2'($urandom); route = 2'($urandom); lint = 1'($urandom);
      step();
    end
    idle();
    step();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule